// File: doc/BRIEF.md
# PHY Presence and Link Tracker

This block tracks which of 32 management addresses answer, and which of them report an active link. It reads the completion reports of a separate management-bus engine. Each report gives the PHY address, the register address, the direction, whether the PHY acknowledged, and the read data. An acknowledged access marks the PHY present. A missed acknowledge marks it absent. A read of the basic status register (register 1) refreshes that PHY's link bit from bit 2 of the returned word.

Two monitor selections each watch one address. For each selection a source bit picks either the tracked link vector or an external link pin. The external pins go through a two-flop synchronizer. When the watched link value changes, the selection's raw event bit is set. Its masked bit is set as well when the selection's interrupt enable is high. The host can clear the event bits. In test mode the host can also set them. A single interrupt output is the OR of the masked bits.

Top module: `phy_status_tracker`

## Requirements
- R1: A completion report (`rpt_vld`=1) writes `rpt_ack` into `alive[rpt_phy]` at the next clock edge. It does this for reads and writes to any register, and leaves every other alive bit unchanged.
- R2: A pulse on `alive_clr_we` clears every alive bit whose `alive_clr_mask` bit is 1 and leaves the bits that are 0 untouched. When a report names the same address in the same cycle, the report wins for that bit.
- R3: A read report (`rpt_rd`=1) with `rpt_reg`=1 sets `link[rpt_phy]` to `rpt_ack` AND `rpt_rdata[2]`. That clears the bit on a missed acknowledge or a zero link flag. Any other report leaves `link` unchanged.
- R4: The link vector has no host write path. A clear of all alive bits leaves `link` unchanged.
- R5: For selection i, `mon_pinsel[i]`=0 takes the link value from `link[mon_addr[i*5 +: 5]]`. `mon_pinsel[i]`=1 takes it from `ext_link[i]` after two synchronizer flops, so `evt_raw[i]` sets on the third clock edge after the pin changes. The unselected source causes no event.
- R6: A change of a selection's link value sets `evt_raw[i]` one edge after the `link` update that caused it. `evt_masked[i]` is set at the same edge only when `mon_inten[i]`=1.
- R7: With `test_en`=0, a write pulse (`evt_wr`) with `evt_wdata[i]`=1 clears both `evt_raw[i]` and `evt_masked[i]`. A data bit of 0 leaves that selection unchanged.
- R8: With `test_en`=1, a write pulse with `evt_wdata[i]`=1 sets both `evt_raw[i]` and `evt_masked[i]`.
- R9: Bit 0 of the event vectors belongs to selection 0 and bit 1 to selection 1. `irq` is high exactly when some `evt_masked` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rpt_vld | input | 1 | Completion report valid |
| rpt_phy | input | 5 | PHY address of the completed access |
| rpt_reg | input | 5 | Register address of the completed access |
| rpt_rd | input | 1 | 1 for a read, 0 for a write |
| rpt_ack | input | 1 | PHY acknowledged the access |
| rpt_rdata | input | 16 | Read data returned by the PHY |
| alive_clr_we | input | 1 | Alive clear strobe |
| alive_clr_mask | input | 32 | Alive bits to clear (1 = clear) |
| mon_addr | input | 10 | Watched address, 5 bits per selection, selection 0 in the low bits |
| mon_inten | input | 2 | Per-selection interrupt enable |
| mon_pinsel | input | 2 | Per-selection link source (1 = external pin) |
| ext_link | input | 2 | Asynchronous external link pins |
| test_en | input | 1 | Test mode: event writes set instead of clear |
| evt_wr | input | 1 | Event register write strobe |
| evt_wdata | input | 2 | Event write data, one bit per selection |
| alive | output | 32 | Presence vector |
| link | output | 32 | Link vector |
| evt_raw | output | 2 | Raw link-change bits |
| evt_masked | output | 2 | Enabled link-change bits |
| irq | output | 1 | OR of masked bits |

## Verification
Alive and link bits change at the first edge after a report, and raw and masked events one edge later. A pin change reaches the raw bit at the third edge, and event writes act at the first edge. The bench drives inputs on the falling edge. It samples after the exact number of rising edges each result needs. For the pin path it also samples one edge early to confirm the bit has not yet set. Cases that must have no effect are sampled at the same point the effect would have appeared.

// File: rtl/phy_track_pkg.sv
package phy_track_pkg;
  localparam int unsigned PT_NPHY     = 32;
  localparam int unsigned PT_ADDR_W   = 5;
  localparam int unsigned PT_DATA_W   = 16;
  localparam int unsigned PT_NSEL     = 2;
  localparam int unsigned PT_STAT_REG = 1;
  localparam int unsigned PT_LINK_BIT = 2;
endpackage

// File: rtl/phy_vec_reg.sv
module phy_vec_reg
  import phy_track_pkg::*;
#(
  parameter int unsigned NPHY     = PT_NPHY,
  parameter int unsigned ADDR_W   = PT_ADDR_W,
  parameter int unsigned DATA_W   = PT_DATA_W,
  parameter int unsigned STAT_REG = PT_STAT_REG,
  parameter int unsigned LINK_BIT = PT_LINK_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_vld,
  input  logic [ADDR_W-1:0] rpt_phy,
  input  logic [ADDR_W-1:0] rpt_reg,
  input  logic              rpt_rd,
  input  logic              rpt_ack,
  input  logic [DATA_W-1:0] rpt_rdata,
  input  logic              clr_we,
  input  logic [NPHY-1:0]   clr_mask,
  output logic [NPHY-1:0]   alive,
  output logic [NPHY-1:0]   link
);
  logic [NPHY-1:0] alive_q, alive_d, link_q, link_d;
  logic            stat_rd;

  assign stat_rd = rpt_vld && rpt_rd && (rpt_reg == ADDR_W'(STAT_REG));

  always_comb begin
    alive_d = alive_q;
    if (clr_we) alive_d = alive_q & ~clr_mask;
    if (rpt_vld) alive_d[rpt_phy] = rpt_ack;
  end

  always_comb begin
    link_d = link_q;
    if (stat_rd) link_d[rpt_phy] = rpt_ack & rpt_rdata[LINK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= '0;
      link_q  <= '0;
    end else begin
      if (rpt_vld || clr_we) alive_q <= alive_d;
      if (stat_rd)           link_q  <= link_d;
    end
  end

  assign alive = alive_q;
  assign link  = link_q;

  // R1: presence bit follows the acknowledge of the last report
  a_r1_alive_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld |=> alive_q[$past(rpt_phy)] == $past(rpt_ack));
  // R2: a cleared bit not named by a report drops to zero
  a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !rpt_vld) |=> ((alive_q & $past(clr_mask)) == '0));
  // R3: status read sets link to ack and flag
  a_r3_link_update: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> link_q[$past(rpt_phy)] == $past(rpt_ack & rpt_rdata[LINK_BIT]));
  // R4: no other stimulus moves the link vector
  a_r4_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> $stable(link_q));
endmodule

// File: rtl/link_sync.sv
module link_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= pin_in[g];
        s2_q <= s1_q;
      end
    end
    assign pin_sync[g] = s2_q;
  end
endmodule

// File: rtl/link_evt.sv
module link_evt
  import phy_track_pkg::*;
#(
  parameter int unsigned NPHY   = PT_NPHY,
  parameter int unsigned ADDR_W = PT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPHY-1:0]   link_vec,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pin_link,
  input  logic              pinsel,
  input  logic              inten,
  input  logic              test_en,
  input  logic              wr,
  input  logic              wbit,
  output logic              raw,
  output logic              masked
);
  logic sel_link, prev_q, chg;
  logic raw_q, raw_d, msk_q, msk_d;

  assign sel_link = pinsel ? pin_link : link_vec[addr];
  assign chg      = sel_link ^ prev_q;

  always_comb begin
    raw_d = raw_q;
    msk_d = msk_q;
    if (wr && wbit) begin
      raw_d = test_en;
      msk_d = test_en;
    end
    if (chg) begin
      raw_d = 1'b1;
      if (inten) msk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
      msk_q  <= 1'b0;
    end else begin
      prev_q <= sel_link;
      if (chg || (wr && wbit)) begin
        raw_q <= raw_d;
        msk_q <= msk_d;
      end
    end
  end

  assign raw    = raw_q;
  assign masked = msk_q;

  // R6: masked bit never stands without its raw bit
  a_r6_masked_implies_raw: assert property (@(posedge clk) disable iff (!rst_n)
    msk_q |-> raw_q);
  // R6: masked bit rises only with enable or a test write
  a_r6_masked_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msk_q) |-> $past(inten) || $past(wr && wbit && test_en));
  // R7: clearing write with no change empties both bits
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wbit && !test_en && !chg) |=> (!raw_q && !msk_q));
  // R8: test write sets both bits
  a_r8_test_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wbit && test_en) |=> (raw_q && msk_q));
endmodule

// File: rtl/phy_status_tracker.sv
module phy_status_tracker
  import phy_track_pkg::*;
#(
  parameter int unsigned NPHY     = PT_NPHY,
  parameter int unsigned ADDR_W   = PT_ADDR_W,
  parameter int unsigned DATA_W   = PT_DATA_W,
  parameter int unsigned NSEL     = PT_NSEL,
  parameter int unsigned STAT_REG = PT_STAT_REG,
  parameter int unsigned LINK_BIT = PT_LINK_BIT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rpt_vld,
  input  logic [ADDR_W-1:0]        rpt_phy,
  input  logic [ADDR_W-1:0]        rpt_reg,
  input  logic                     rpt_rd,
  input  logic                     rpt_ack,
  input  logic [DATA_W-1:0]        rpt_rdata,
  input  logic                     alive_clr_we,
  input  logic [NPHY-1:0]          alive_clr_mask,
  input  logic [NSEL*ADDR_W-1:0]   mon_addr,
  input  logic [NSEL-1:0]          mon_inten,
  input  logic [NSEL-1:0]          mon_pinsel,
  input  logic [NSEL-1:0]          ext_link,
  input  logic                     test_en,
  input  logic                     evt_wr,
  input  logic [NSEL-1:0]          evt_wdata,
  output logic [NPHY-1:0]          alive,
  output logic [NPHY-1:0]          link,
  output logic [NSEL-1:0]          evt_raw,
  output logic [NSEL-1:0]          evt_masked,
  output logic                     irq
);
  logic rst_m_q, rst_s_q;
  logic [NSEL-1:0] pin_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  phy_vec_reg #(
    .NPHY(NPHY), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_REG(STAT_REG), .LINK_BIT(LINK_BIT)
  ) u_vec (
    .clk(clk), .rst_n(rst_s_q),
    .rpt_vld(rpt_vld), .rpt_phy(rpt_phy), .rpt_reg(rpt_reg),
    .rpt_rd(rpt_rd), .rpt_ack(rpt_ack), .rpt_rdata(rpt_rdata),
    .clr_we(alive_clr_we), .clr_mask(alive_clr_mask),
    .alive(alive), .link(link)
  );

  link_sync #(.WIDTH(NSEL)) u_sync (
    .clk(clk), .rst_n(rst_s_q), .pin_in(ext_link), .pin_sync(pin_sync)
  );

  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    link_evt #(.NPHY(NPHY), .ADDR_W(ADDR_W)) u_evt (
      .clk(clk), .rst_n(rst_s_q),
      .link_vec(link), .addr(mon_addr[s*ADDR_W +: ADDR_W]),
      .pin_link(pin_sync[s]), .pinsel(mon_pinsel[s]), .inten(mon_inten[s]),
      .test_en(test_en), .wr(evt_wr), .wbit(evt_wdata[s]),
      .raw(evt_raw[s]), .masked(evt_masked[s])
    );
  end

  assign irq = |evt_masked;

  // R9: interrupt high only while an enabled event is pending
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_s_q)
    irq |-> (evt_raw != '0));
endmodule

// File: tb/phy_status_tracker_bench.sv
module phy_status_tracker_bench;
  logic        clk, rst_n;
  logic        rpt_vld, rpt_rd, rpt_ack;
  logic [4:0]  rpt_phy, rpt_reg;
  logic [15:0] rpt_rdata;
  logic        alive_clr_we;
  logic [31:0] alive_clr_mask;
  logic [9:0]  mon_addr;
  logic [1:0]  mon_inten, mon_pinsel, ext_link, evt_wdata;
  logic        test_en, evt_wr;
  logic [31:0] alive, link;
  logic [1:0]  evt_raw, evt_masked;
  logic        irq;
  int checks = 0, errors = 0;

  phy_status_tracker u_phy_status_tracker (
    .clk(clk), .rst_n(rst_n), .rpt_vld(rpt_vld), .rpt_phy(rpt_phy),
    .rpt_reg(rpt_reg), .rpt_rd(rpt_rd), .rpt_ack(rpt_ack), .rpt_rdata(rpt_rdata),
    .alive_clr_we(alive_clr_we), .alive_clr_mask(alive_clr_mask),
    .mon_addr(mon_addr), .mon_inten(mon_inten), .mon_pinsel(mon_pinsel),
    .ext_link(ext_link), .test_en(test_en), .evt_wr(evt_wr), .evt_wdata(evt_wdata),
    .alive(alive), .link(link), .evt_raw(evt_raw), .evt_masked(evt_masked), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic        rd;
    logic        ack;
    logic [15:0] data;
    logic        exp_alive;
    logic        exp_link;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{5'd5,  5'd1, 1'b1, 1'b1, 16'h0004, 1'b1, 1'b1},
    '{5'd5,  5'd1, 1'b1, 1'b0, 16'h0004, 1'b0, 1'b0},
    '{5'd5,  5'd1, 1'b1, 1'b1, 16'h0004, 1'b1, 1'b1},
    '{5'd5,  5'd0, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b1},
    '{5'd5,  5'd1, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1},
    '{5'd5,  5'd1, 1'b1, 1'b1, 16'hFFFB, 1'b1, 1'b0},
    '{5'd31, 5'd1, 1'b1, 1'b1, 16'h0004, 1'b1, 1'b1},
    '{5'd0,  5'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{5'd31, 5'd9, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic report(input logic [4:0] p, input logic [4:0] r, input logic rd,
                        input logic ack, input logic [15:0] d);
    rpt_vld = 1'b1; rpt_phy = p; rpt_reg = r; rpt_rd = rd; rpt_ack = ack; rpt_rdata = d;
    step(1);
    rpt_vld = 1'b0;
  endtask

  task automatic evt_write(input logic tm, input logic [1:0] d);
    test_en = tm; evt_wr = 1'b1; evt_wdata = d;
    step(1);
    evt_wr = 1'b0; test_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rpt_vld = 0; rpt_phy = 0; rpt_reg = 0; rpt_rd = 0; rpt_ack = 0;
    rpt_rdata = 0; alive_clr_we = 0; alive_clr_mask = 0;
    mon_addr = {5'd7, 5'd3}; mon_inten = 2'b01; mon_pinsel = 2'b10; ext_link = 2'b00;
    test_en = 0; evt_wr = 0; evt_wdata = 0;
    step(3);
    check("R1 reset alive", alive, 32'h0);
    check("R3 reset link", link, 32'h0);
    check("R9 reset events", {29'd0, irq, evt_raw}, 32'h0);
    rst_n = 1'b1;
    step(4);

    for (int k = 0; k < NV; k++) begin
      report(TBL[k].phy, TBL[k].rg, TBL[k].rd, TBL[k].ack, TBL[k].data);
      check($sformatf("R1 alive vec %0d", k), {31'd0, alive[TBL[k].phy]}, {31'd0, TBL[k].exp_alive});
      check($sformatf("R3 link vec %0d", k), {31'd0, link[TBL[k].phy]}, {31'd0, TBL[k].exp_link});
    end
    check("R1 other alive bits untouched", alive, 32'h0000_0020);
    check("R6 no event from unwatched addresses", {30'd0, evt_raw}, 32'h0);

    // R2: write 0 mask has no effect, then clear bit 5
    alive_clr_we = 1'b1; alive_clr_mask = 32'h0; step(1);
    check("R2 zero mask keeps alive", alive, 32'h0000_0020);
    alive_clr_mask = 32'hFFFF_FFFF; step(1); alive_clr_we = 1'b0;
    check("R2 clear all alive", alive, 32'h0);
    check("R4 link kept after alive clear", link, 32'h8000_0000);
    // R2: report and clear of the same bit in one cycle, report wins
    alive_clr_we = 1'b1; alive_clr_mask = 32'h0000_0400;
    report(5'd10, 5'd4, 1'b0, 1'b1, 16'h0);
    alive_clr_we = 1'b0;
    check("R2 report wins over clear", alive, 32'h0000_0400);

    // R6: watched link of selection 0 changes
    report(5'd3, 5'd1, 1'b1, 1'b1, 16'h0004);
    check("R6 event not yet at link edge", {30'd0, evt_raw}, 32'h0);
    step(1);
    check("R6 raw set", {30'd0, evt_raw}, 32'h1);
    check("R6 masked set with enable", {30'd0, evt_masked}, 32'h1);
    check("R9 irq from sel0", {31'd0, irq}, 32'h1);
    evt_write(1'b0, 2'b01);
    check("R7 clear raw and masked", {28'd0, evt_raw, evt_masked}, 32'h0);
    check("R9 irq drops", {31'd0, irq}, 32'h0);

    // R8: test-mode set, then R7 write-0 and per-bit clear
    evt_write(1'b1, 2'b11);
    check("R8 test set both", {28'd0, evt_raw, evt_masked}, 32'hF);
    evt_write(1'b0, 2'b00);
    check("R7 zero write no effect", {28'd0, evt_raw, evt_masked}, 32'hF);
    evt_write(1'b0, 2'b10);
    check("R9 bit1 maps to sel1", {28'd0, evt_raw, evt_masked}, 32'h5);
    evt_write(1'b0, 2'b01);
    check("R7 sel0 cleared", {28'd0, evt_raw, evt_masked}, 32'h0);

    // R5: pin source on sel1, pin ignored on sel0
    ext_link = 2'b11;
    step(2);
    check("R5 pin not yet through sync", {30'd0, evt_raw}, 32'h0);
    step(1);
    check("R5 sel1 raw from pin", {30'd0, evt_raw}, 32'h2);
    check("R6 sel1 masked held low without enable", {30'd0, evt_masked}, 32'h0);
    check("R9 irq low with only unmasked event", {31'd0, irq}, 32'h0);
    step(3);
    check("R5 sel0 ignores its pin", {31'd0, evt_raw[0]}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule